// File: doc/BRIEF.md
# Optical-Black Level Loop Controller

This block is the digital half of a black-level correction loop placed behind a pixel converter. While the optical-black window is open, it compares each converter sample against a programmed target code. It then commands an external charge pump to raise the offset, lower it, or leave it alone. Outside the window the pump is told to hold, so the stored correction stays frozen while active pixels pass.

The loop can settle faster for a short while after the host reprograms the chip. Every serial-port access, seen as a falling edge of the port's chip select, restarts a small counter of completed optical-black windows. The loop gain flag stays high until a programmable number of windows has finished, and then drops. Two settings override this: a window count of zero keeps the gain low, and an override bit keeps it high. A capacitor-reset request goes out whenever the stored correction has to be discarded.

Converter samples arrive as a stream qualified by `code_valid`. The block accepts one sample in every clock cycle and never applies back-pressure, so the stream has no ready signal. A cycle without `code_valid` counts as no sample.

Top module: `black_level_loop`

## Requirements
- R1: While `rst_n` is low, `cap_reset_req` is 1. On the first clock after reset is released, `pump_hold`=1, `pump_up`=0, `pump_down`=0 and `gain_high`=0, provided `boost_cfg_always`=0.
- R2: In a clock where `ob_pulse`=1 and `code_valid`=1 and no capacitor reset is requested, the sample is compared with the target. After that edge `pump_up`=1 if code < target, `pump_down`=1 if code > target, and both are 0 if the two are equal. In all three cases `pump_hold`=0.
- R3: In a clock where `ob_pulse`=0 or `code_valid`=0, the outputs after that edge are `pump_hold`=1, `pump_up`=0 and `pump_down`=0.
- R4: A target code of 0 is treated as 64. Targets from 1 to 127 are used as given, compared unsigned against the 10-bit code.
- R5: A falling edge of `cs_n` passes through a two-flop synchroniser and is then detected. This resets the window count to zero at the third rising clock edge after `cs_n` is first sampled low, and `gain_high` rises from that edge.
- R6: After a restart, `gain_high` stays 1 until `boost_cfg_len` optical-black windows have ended. A window ends on the clock where `ob_pulse` is seen falling. The count then saturates and `gain_high` returns to 0.
- R7: With `boost_cfg_len`=0 and `boost_cfg_always`=0, `gain_high` is 0 even right after a serial access.
- R8: With `boost_cfg_always`=1, `gain_high` is 1 whatever the count.
- R9: `cap_reset_req` is the combinational OR of `blk_clr_cfg`, `pd_cfg`, `!stby_n` and `!rst_n`.
- R10: In a clock where `cap_reset_req` is 1, the pump outputs after that edge are `pump_hold`=1, `pump_up`=0 and `pump_down`=0, even inside the optical-black window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low; also requests a capacitor reset |
| stby_n | input | 1 | Standby pin, active low; requests a capacitor reset |
| pd_cfg | input | 1 | Power-down configuration bit |
| blk_clr_cfg | input | 1 | Black-level clear configuration bit |
| code_valid | input | 1 | Converter sample qualifier |
| code | input | 10 | Converter output code, straight binary |
| ob_pulse | input | 1 | Optical-black window, active high, synchronous to clk |
| cs_n | input | 1 | Serial-port chip select, asynchronous, active low |
| target_code | input | 7 | Target black code in LSB |
| boost_cfg_len | input | 3 | Number of windows with high gain after an access |
| boost_cfg_always | input | 1 | Forces high loop gain |
| pump_up | output | 1 | Raise the black level |
| pump_down | output | 1 | Lower the black level |
| pump_hold | output | 1 | Freeze the stored correction |
| gain_high | output | 1 | High loop gain select |
| cap_reset_req | output | 1 | Request to discharge the correction capacitor |

## Verification
The comparator is driven with codes below, equal to, and above the target. This includes the neighbours of the target, codes far above it, and target 0. Together these separate an off-by-one in the compare from a wrong default. The same codes are also sent outside the window and without `code_valid`, which shows whether the hold qualification uses both signals. Boost behaviour is tried with windows of several lengths after a single short chip-select pulse, with a zero count, and with the override; this exposes wrong edge selection, wrong saturation and a wrong restart delay. A long stretch of mixed random inputs, including clear and power-down events, is then checked against a behavioural model on every clock.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    PUMP_HOLD = 2'd0,
    PUMP_UP   = 2'd1,
    PUMP_DN   = 2'd2,
    PUMP_IDLE = 2'd3
  } pump_cmd_e;
endpackage

// File: rtl/blc_sync_fall.sv
module blc_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], async_n};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/blc_boost.sv
module blc_boost #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ob_active,
  input  logic [LEN_W-1:0] len,
  input  logic             force_high,
  output logic             gain_high
);
  localparam logic [LEN_W-1:0] CNT_IDLE = '1;

  logic [LEN_W-1:0] cnt;
  logic             ob_q;
  logic             ob_end;

  assign ob_end = ob_q & ~ob_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CNT_IDLE;
      ob_q <= 1'b0;
    end else begin
      ob_q <= ob_active;
      if (restart)                  cnt <= '0;
      else if (ob_end && cnt < len) cnt <= cnt + 1'b1;
    end
  end

  assign gain_high = force_high | (cnt < len);

  // R5: a detected access clears the count
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  // R6: count saturates once it reaches the programmed length
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt >= len) |=> cnt == $past(cnt));
  // R6: count only moves at the end of a window
  p_end_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ob_end) |=> $stable(cnt));
endmodule

// File: rtl/blc_compare.sv
module blc_compare
  import blc_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int TGT_W   = 7,
  parameter int DEF_TGT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code,
  input  logic              ob_active,
  input  logic [TGT_W-1:0]  target,
  input  logic              freeze,
  output pump_cmd_e         cmd
);
  localparam int CMP_W = (CODE_W > TGT_W) ? CODE_W : TGT_W;

  logic [CMP_W-1:0] tgt_eff;
  logic [CMP_W-1:0] code_x;
  pump_cmd_e        cmd_d;

  always_comb begin
    tgt_eff = (target == '0) ? CMP_W'(DEF_TGT) : CMP_W'(target);
    code_x  = CMP_W'(code);
    if (freeze)                       cmd_d = PUMP_HOLD;
    else if (ob_active && code_valid) begin
      if (code_x < tgt_eff)           cmd_d = PUMP_UP;
      else if (code_x > tgt_eff)      cmd_d = PUMP_DN;
      else                            cmd_d = PUMP_IDLE;
    end else                          cmd_d = PUMP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd <= PUMP_HOLD;
    else        cmd <= cmd_d;
  end

  // R3: no qualified sample means hold next cycle
  p_hold_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ob_active && code_valid) |=> cmd == PUMP_HOLD);
  // R10: a capacitor reset freezes the pump
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> cmd == PUMP_HOLD);
endmodule

// File: rtl/black_level_loop.sv
module black_level_loop
  import blc_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int TGT_W       = 7,
  parameter int LEN_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_TGT     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_n,
  input  logic              pd_cfg,
  input  logic              blk_clr_cfg,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code,
  input  logic              ob_pulse,
  input  logic              cs_n,
  input  logic [TGT_W-1:0]  target_code,
  input  logic [LEN_W-1:0]  boost_cfg_len,
  input  logic              boost_cfg_always,
  output logic              pump_up,
  output logic              pump_down,
  output logic              pump_hold,
  output logic              gain_high,
  output logic              cap_reset_req
);
  logic      freeze;
  logic      access_fall;
  pump_cmd_e cmd;

  assign freeze        = blk_clr_cfg | pd_cfg | ~stby_n;
  assign cap_reset_req = freeze | ~rst_n;

  blc_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (cs_n),
    .fall    (access_fall)
  );

  blc_boost #(.LEN_W(LEN_W)) u_boost (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (access_fall),
    .ob_active  (ob_pulse),
    .len        (boost_cfg_len),
    .force_high (boost_cfg_always),
    .gain_high  (gain_high)
  );

  blc_compare #(.CODE_W(CODE_W), .TGT_W(TGT_W), .DEF_TGT(DEF_TGT)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code       (code),
    .ob_active  (ob_pulse),
    .target     (target_code),
    .freeze     (freeze),
    .cmd        (cmd)
  );

  assign pump_up   = (cmd == PUMP_UP);
  assign pump_down = (cmd == PUMP_DN);
  assign pump_hold = (cmd == PUMP_HOLD);

  // R2: pump pins never conflict
  p_pins_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pump_up, pump_down, pump_hold}));
  // R10: a reset request is followed by hold
  p_req_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_reset_req |=> pump_hold);
endmodule

// File: tb/black_level_loop_test.sv
module black_level_loop_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, stby_n, pd_cfg, blk_clr_cfg, code_valid, ob_pulse, cs_n, boost_cfg_always;
  logic [9:0] code;
  logic [6:0] target_code;
  logic [2:0] boost_cfg_len;
  logic       pump_up, pump_down, pump_hold, gain_high, cap_reset_req;

  black_level_loop uut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .pd_cfg(pd_cfg), .blk_clr_cfg(blk_clr_cfg),
    .code_valid(code_valid), .code(code), .ob_pulse(ob_pulse), .cs_n(cs_n),
    .target_code(target_code), .boost_cfg_len(boost_cfg_len), .boost_cfg_always(boost_cfg_always),
    .pump_up(pump_up), .pump_down(pump_down), .pump_hold(pump_hold),
    .gain_high(gain_high), .cap_reset_req(cap_reset_req)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // behavioural reference state
  bit m_up, m_dn, m_hold, m_obp;
  int m_cnt;
  bit csq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_hold = 1; m_cnt = 7; m_obp = 0;
      csq = '{1'b1, 1'b1, 1'b1};
    end else begin
      int t;
      bit csf;
      t = (target_code == 0) ? 64 : int'(target_code);
      if (blk_clr_cfg || pd_cfg || !stby_n) begin
        m_up = 0; m_dn = 0; m_hold = 1;
      end else if (ob_pulse && code_valid) begin
        m_up = int'(code) < t; m_dn = int'(code) > t; m_hold = 0;
      end else begin
        m_up = 0; m_dn = 0; m_hold = 1;
      end
      csf = csq[2] && !csq[1];
      csq.push_front(cs_n);
      void'(csq.pop_back());
      if (csf) m_cnt = 0;
      else if (m_obp && !ob_pulse && m_cnt < int'(boost_cfg_len)) m_cnt++;
      m_obp = ob_pulse;
    end
    #2;
    if (!done) begin
      bit eg, ec;
      eg = boost_cfg_always || (m_cnt < int'(boost_cfg_len));
      ec = !rst_n || blk_clr_cfg || pd_cfg || !stby_n;
      chk(pump_up == m_up,     "R2 pump_up",   pump_up,   m_up);
      chk(pump_down == m_dn,   "R2 pump_down", pump_down, m_dn);
      chk(pump_hold == m_hold, "R3 pump_hold", pump_hold, m_hold);
      chk(gain_high == eg,     "R6 gain_high", gain_high, eg);
      chk(cap_reset_req == ec, "R9 cap_reset_req", cap_reset_req, ec);
    end
  end

  task automatic sample(input bit v, input int c, input bit ob);
    @(negedge clk);
    code_valid = v; code = 10'(c); ob_pulse = ob;
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  task automatic access_pulse();
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  initial begin
    rst_n = 0; stby_n = 1; pd_cfg = 0; blk_clr_cfg = 0; code_valid = 0; code = '0;
    ob_pulse = 0; cs_n = 1; target_code = 7'd64; boost_cfg_len = 3'd0; boost_cfg_always = 0;
    repeat (3) @(negedge clk);
    chk(cap_reset_req == 1'b1, "R1 reset request", cap_reset_req, 1);
    rst_n = 1;
    after_edge();
    chk(pump_hold && !pump_up && !pump_down, "R1 pump after reset", {pump_up, pump_down, pump_hold}, 1);
    chk(gain_high == 1'b0, "R1 gain after reset", gain_high, 0);

    // R2 compare patterns
    sample(1, 10, 1);  after_edge(); chk(pump_up == 1'b1, "R2 below", pump_up, 1);
    sample(1, 64, 1);  after_edge(); chk(!pump_up && !pump_down && !pump_hold, "R2 equal", {pump_up, pump_down, pump_hold}, 0);
    sample(1, 500, 1); after_edge(); chk(pump_down == 1'b1, "R2 above", pump_down, 1);
    sample(1, 63, 1);  sample(1, 65, 1); sample(1, 1023, 1);
    // R3 outside window and invalid sample
    sample(1, 10, 0);  after_edge(); chk(pump_hold == 1'b1, "R3 outside window", pump_hold, 1);
    sample(0, 10, 1);  after_edge(); chk(pump_hold == 1'b1, "R3 invalid sample", pump_hold, 1);
    // R4 target zero maps to 64
    @(negedge clk); target_code = 7'd0;
    sample(1, 63, 1);  after_edge(); chk(pump_up == 1'b1, "R4 zero target below", pump_up, 1);
    sample(1, 64, 1);  after_edge(); chk(!pump_up && !pump_down, "R4 zero target equal", {pump_up, pump_down}, 0);
    sample(1, 65, 1);  after_edge(); chk(pump_down == 1'b1, "R4 zero target above", pump_down, 1);
    @(negedge clk); target_code = 7'd127;
    sample(1, 127, 1); after_edge(); chk(!pump_up && !pump_down, "R4 target 127 equal", {pump_up, pump_down}, 0);
    @(negedge clk); target_code = 7'd16;
    sample(1, 15, 1);  sample(0, 0, 0);

    // R5 restart timing, R6 window counting
    @(negedge clk); boost_cfg_len = 3'd3;
    @(negedge clk); cs_n = 1'b0;
    @(posedge clk);
    @(negedge clk); cs_n = 1'b1;
    after_edge(); chk(gain_high == 1'b0, "R5 before restart", gain_high, 0);
    after_edge(); chk(gain_high == 1'b1, "R5 restart edge", gain_high, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ob_pulse = 1'b1; code_valid = 1'b1; code = 10'd20;
      repeat (3) @(negedge clk);
      ob_pulse = 1'b0;
      after_edge();
      chk(gain_high == (i < 2), "R6 window count", gain_high, (i < 2));
    end

    // R7 zero length
    @(negedge clk); boost_cfg_len = 3'd0;
    access_pulse();
    repeat (4) after_edge();
    chk(gain_high == 1'b0, "R7 zero length", gain_high, 0);
    // R8 override
    @(negedge clk); boost_cfg_always = 1'b1;
    after_edge(); chk(gain_high == 1'b1, "R8 always high", gain_high, 1);
    @(negedge clk); boost_cfg_always = 1'b0;

    // R10 / R9 freeze sources
    @(negedge clk); target_code = 7'd64; blk_clr_cfg = 1'b1; ob_pulse = 1; code_valid = 1; code = 10'd5;
    after_edge(); chk(pump_hold && !pump_up, "R10 clear freezes", {pump_up, pump_hold}, 1);
    chk(cap_reset_req == 1'b1, "R9 clear bit", cap_reset_req, 1);
    @(negedge clk); blk_clr_cfg = 1'b0; pd_cfg = 1'b1;
    after_edge(); chk(pump_hold == 1'b1, "R10 power-down freezes", pump_hold, 1);
    @(negedge clk); pd_cfg = 1'b0; stby_n = 1'b0;
    after_edge(); chk(cap_reset_req == 1'b1, "R9 standby pin", cap_reset_req, 1);
    @(negedge clk); stby_n = 1'b1;
    after_edge(); chk(pump_up == 1'b1, "R10 release", pump_up, 1);

    // mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      code_valid = ($urandom % 8) != 0;
      code = 10'($urandom % 160);
      if ($urandom % 6 == 0) ob_pulse = ~ob_pulse;
      if ($urandom % 40 == 0) target_code = 7'($urandom % 128);
      if ($urandom % 60 == 0) boost_cfg_len = 3'($urandom % 8);
      cs_n = ($urandom % 50) != 0;
      boost_cfg_always = ($urandom % 30) == 0;
      blk_clr_cfg = ($urandom % 40) == 0;
      pd_cfg = ($urandom % 50) == 0;
      stby_n = ($urandom % 50) != 0;
    end
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule